// File: doc/BRIEF.md
# Memory Map Decoder with Boot Overlay

This block sits between an 8-bit CPU with a 16-bit address bus and the memories and register ports around it. Every read or write strobe is decoded into exactly one region: a 256-byte start-up ROM, a 32 KB program ROM, video RAM, cartridge-side RAM, work RAM, a work RAM mirror, a 128-byte fast RAM, the joypad register or the video-controller register port. For the selected region it drives a one-hot select, a write enable and a local index. The memories live outside the block. Each one presents its byte on its own read-data input. The block picks the matching byte and registers it.

A start-up ROM covers the bottom of the program ROM space after reset. A two-state machine holds this cover. In state `OVL_ACTIVE`, reads of 0x0000–0x00FE are served by the start-up ROM. The machine takes the transition `RETIRE` to state `OVL_RETIRED` in two cases: when the CPU reads 0x00FE, or on any write to 0xFF50. `OVL_RETIRED` has no exit except reset. Video RAM writes below 0x9800 also raise a tile-update strobe, which carries the local address and the data.

Top module: `mem_map_decoder`

## Requirements
- R1: After reset, `overlay_on` is 1 and `cpu_rdata` is 0x00.
- R2: While the overlay is on, an access to 0x0000–0x00FE selects the start-up ROM (`region_sel` bit 0) with index equal to the address. Address 0x00FF still selects program ROM.
- R3: A read of 0x00FE while the overlay is on returns the start-up ROM byte. `overlay_on` falls on that same clock edge. After that, low addresses read program ROM. The overlay never turns back on without reset.
- R4: Any write to 0xFF50 clears `overlay_on` on the write's clock edge.
- R5: 0x0000–0x7FFF select program ROM (`region_sel` bit 1) with index equal to address bits 14:0. Writes there assert no bit of `region_we`.
- R6: 0x8000–0x9FFF, 0xA000–0xBFFF and 0xC000–0xDFFF select video RAM (bit 2), external RAM (bit 3) and work RAM (bit 4). The index is the address AND 0x1FFF. A write asserts only the matching `region_we` bit.
- R7: 0xE000–0xFDFF select work RAM (bit 4) with index equal to the address AND 0x1FFF, for reads and for writes.
- R8: 0xFF80–0xFFFF select high RAM (bit 5) with index equal to address bits 6:0. Writes there are enabled.
- R9: 0xFF00 selects the joypad register (bit 6). 0xFF40–0xFF7F select the video register port (bit 7) with index equal to address bits 5:0.
- R10: A video RAM write below 0x9800 pulses `tile_stb` in the same cycle, with `tile_addr` equal to the address AND 0x1FFF and `tile_data` equal to the write data. Video RAM writes at 0x9800 or above leave it low.
- R11: Addresses 0xFE00–0xFEFF, and I/O addresses outside R8/R9, select nothing and enable no write. A read of one of them returns 0x00.
- R12: `cpu_rdata` takes its new value on the clock edge that samples `cpu_rd`. Without `cpu_rd` it holds its value.
- R13: With neither strobe high, `region_sel` and `region_we` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| boot_rdata | input | 8 | Start-up ROM byte at `mem_index` |
| rom_rdata | input | 8 | Program ROM byte |
| vram_rdata | input | 8 | Video RAM byte |
| eram_rdata | input | 8 | External RAM byte |
| wram_rdata | input | 8 | Work RAM byte |
| hram_rdata | input | 8 | High RAM byte |
| joy_rdata | input | 8 | Joypad register |
| vreg_rdata | input | 8 | Video register port byte |
| region_sel | output | 8 | One-hot region select (bits as in R2–R9) |
| region_we | output | 8 | Per-region write enable |
| mem_index | output | 15 | Local index inside the selected region |
| tile_stb | output | 1 | Tile-update strobe |
| tile_addr | output | 13 | Tile-update local address |
| tile_data | output | 8 | Tile-update data |
| overlay_on | output | 1 | Boot overlay flag |

## Verification
The bench targets the edges of the overlay. It probes 0x00FE against 0x00FF: a decoder that compares the overlay limit inclusively would serve 0x00FF from the start-up ROM. It reads 0x00FE itself: a machine that retires one cycle early would return a program ROM byte there. It checks the mirror at 0xE000 and at 0xFD00 against the plain work RAM index, because a wrong mask would land in another work RAM byte. It also probes the tile limit at 0x9800 and the empty 0xFE00 and 0xFF10 holes. A decoder with an off-by-one limit would pulse the strobe at 0x9800, or would return stale data instead of 0x00 from the holes.

// File: rtl/mmdec_pkg.sv
package mmdec_pkg;
    typedef enum logic [3:0] {
        RG_BOOT = 4'd0,
        RG_ROM  = 4'd1,
        RG_VRAM = 4'd2,
        RG_ERAM = 4'd3,
        RG_WRAM = 4'd4,
        RG_HRAM = 4'd5,
        RG_JOY  = 4'd6,
        RG_VREG = 4'd7,
        RG_NONE = 4'd8
    } region_e;

    localparam int NUM_REGIONS = 8;

    typedef enum logic {
        OVL_ACTIVE  = 1'b0,
        OVL_RETIRED = 1'b1
    } ovl_state_e;
endpackage

// File: rtl/region_decode.sv
module region_decode
    import mmdec_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int          IDX_W     = 15,
    parameter logic [15:0] BOOT_LAST = 16'h00FE
) (
    input  logic [AW-1:0]    addr,
    input  logic             overlay_on,
    output region_e          region,
    output logic [IDX_W-1:0] index
);
    always_comb begin
        region = RG_NONE;
        index  = '0;
        if (overlay_on && addr <= BOOT_LAST) begin
            region = RG_BOOT;
            index  = IDX_W'(addr[7:0]);
        end else begin
            unique case (addr[15:13])
                3'b000, 3'b001, 3'b010, 3'b011: begin
                    region = RG_ROM;
                    index  = IDX_W'(addr[14:0]);
                end
                3'b100: begin
                    region = RG_VRAM;
                    index  = IDX_W'(addr[12:0]);
                end
                3'b101: begin
                    region = RG_ERAM;
                    index  = IDX_W'(addr[12:0]);
                end
                3'b110: begin
                    region = RG_WRAM;
                    index  = IDX_W'(addr[12:0]);
                end
                3'b111: begin
                    if (addr < 16'hFE00) begin
                        region = RG_WRAM;
                        index  = IDX_W'(addr[12:0]);
                    end else if (addr >= 16'hFF80) begin
                        region = RG_HRAM;
                        index  = IDX_W'(addr[6:0]);
                    end else if (addr == 16'hFF00) begin
                        region = RG_JOY;
                    end else if (addr[15:6] == 10'b1111_1111_01) begin
                        region = RG_VREG;
                        index  = IDX_W'(addr[5:0]);
                    end
                end
                default: region = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/overlay_fsm.sv
module overlay_fsm
    import mmdec_pkg::*;
#(
    parameter logic [15:0] BOOT_LAST = 16'h00FE,
    parameter logic [15:0] EXIT_REG  = 16'hFF50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd,
    input  logic        wr,
    input  logic [15:0] addr,
    output logic        overlay_on
);
    ovl_state_e state, state_nx;
    logic       retire;

    assign retire = (rd && addr == BOOT_LAST) || (wr && addr == EXIT_REG);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= OVL_ACTIVE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            OVL_ACTIVE:  if (retire) state_nx = OVL_RETIRED;
            OVL_RETIRED: state_nx = OVL_RETIRED;
            default:     state_nx = OVL_ACTIVE;
        endcase
    end

    always_comb begin
        unique case (state)
            OVL_ACTIVE:  overlay_on = 1'b1;
            OVL_RETIRED: overlay_on = 1'b0;
            default:     overlay_on = 1'b1;
        endcase
    end
endmodule

// File: rtl/read_capture.sv
module read_capture
    import mmdec_pkg::*;
#(
    parameter int DW = 8,
    parameter int NR = NUM_REGIONS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd,
    input  region_e         region,
    input  logic [NR*DW-1:0] rdata_bus,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0] picked;

    always_comb begin
        if (region == RG_NONE) picked = '0;
        else                   picked = rdata_bus[int'(region)*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= picked;
    end
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
    import mmdec_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          DW         = 8,
    parameter int          IDX_W      = 15,
    parameter int          TILE_W     = 13,
    parameter logic [15:0] BOOT_LAST  = 16'h00FE,
    parameter logic [15:0] EXIT_REG   = 16'hFF50,
    parameter logic [15:0] TILE_LIMIT = 16'h9800
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          cpu_addr,
    input  logic                   cpu_rd,
    input  logic                   cpu_wr,
    input  logic [DW-1:0]          cpu_wdata,
    output logic [DW-1:0]          cpu_rdata,
    input  logic [DW-1:0]          boot_rdata,
    input  logic [DW-1:0]          rom_rdata,
    input  logic [DW-1:0]          vram_rdata,
    input  logic [DW-1:0]          eram_rdata,
    input  logic [DW-1:0]          wram_rdata,
    input  logic [DW-1:0]          hram_rdata,
    input  logic [DW-1:0]          joy_rdata,
    input  logic [DW-1:0]          vreg_rdata,
    output logic [NUM_REGIONS-1:0] region_sel,
    output logic [NUM_REGIONS-1:0] region_we,
    output logic [IDX_W-1:0]       mem_index,
    output logic                   tile_stb,
    output logic [TILE_W-1:0]      tile_addr,
    output logic [DW-1:0]          tile_data,
    output logic                   overlay_on
);
    localparam logic [NUM_REGIONS-1:0] WR_MASK = 8'b1111_1100;

    region_e                   region;
    logic                      access;
    logic [NUM_REGIONS*DW-1:0] rdata_bus;

    assign access = cpu_rd || cpu_wr;

    overlay_fsm #(.BOOT_LAST(BOOT_LAST), .EXIT_REG(EXIT_REG)) u_ovl (
        .clk(clk), .rst_n(rst_n), .rd(cpu_rd), .wr(cpu_wr),
        .addr(cpu_addr), .overlay_on(overlay_on)
    );

    region_decode #(.AW(AW), .IDX_W(IDX_W), .BOOT_LAST(BOOT_LAST)) u_dec (
        .addr(cpu_addr), .overlay_on(overlay_on),
        .region(region), .index(mem_index)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_sel
        assign region_sel[g] = access && (region == region_e'(g));
        assign region_we[g]  = cpu_wr && WR_MASK[g] && (region == region_e'(g));
    end

    assign rdata_bus = {vreg_rdata, joy_rdata, hram_rdata, wram_rdata,
                        eram_rdata, vram_rdata, rom_rdata, boot_rdata};

    read_capture #(.DW(DW), .NR(NUM_REGIONS)) u_cap (
        .clk(clk), .rst_n(rst_n), .rd(cpu_rd), .region(region),
        .rdata_bus(rdata_bus), .rdata(cpu_rdata)
    );

    assign tile_stb  = region_we[RG_VRAM] && (cpu_addr < TILE_LIMIT);
    assign tile_addr = cpu_addr[TILE_W-1:0];
    assign tile_data = cpu_wdata;
endmodule

// File: rtl/mmdec_checks.sv
module mmdec_checks (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [7:0]  cpu_rdata,
    input logic [7:0]  region_sel,
    input logic [7:0]  region_we,
    input logic        tile_stb,
    input logic        overlay_on
);
    p_onehot_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(region_sel));

    p_rom_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_addr[15]) |-> (region_we == 8'h00));

    p_overlay_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !overlay_on |=> !overlay_on);

    p_exit_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'hFF50) |=> !overlay_on);

    p_tile_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tile_stb |-> (cpu_wr && cpu_addr >= 16'h8000 && cpu_addr < 16'h9800));

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd || cpu_wr) |-> (region_sel == 8'h00 && region_we == 8'h00));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> $stable(cpu_rdata));
endmodule

bind mem_map_decoder mmdec_checks u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .region_sel(region_sel),
    .region_we(region_we), .tile_stb(tile_stb), .overlay_on(overlay_on)
);

// File: tb/mem_map_decoder_test.sv
module mem_map_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [7:0]  boot_rdata, rom_rdata, vram_rdata, eram_rdata;
    logic [7:0]  wram_rdata, hram_rdata, joy_rdata, vreg_rdata;
    logic [7:0]  region_sel, region_we;
    logic [14:0] mem_index;
    logic        tile_stb, overlay_on;
    logic [12:0] tile_addr;
    logic [7:0]  tile_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory models: data is a function of the local index
    assign boot_rdata = mem_index[7:0] ^ 8'hB0;
    assign rom_rdata  = mem_index[7:0] ^ {1'b0, mem_index[14:8]} ^ 8'h3C;
    assign vram_rdata = mem_index[7:0] ^ {3'b0, mem_index[12:8]} ^ 8'h11;
    assign eram_rdata = mem_index[7:0] ^ {3'b0, mem_index[12:8]} ^ 8'h22;
    assign wram_rdata = mem_index[7:0] ^ {3'b0, mem_index[12:8]} ^ 8'h44;
    assign hram_rdata = {1'b1, mem_index[6:0]};
    assign joy_rdata  = 8'hCF;
    assign vreg_rdata = {2'b10, mem_index[5:0]};

    mem_map_decoder uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .boot_rdata(boot_rdata), .rom_rdata(rom_rdata), .vram_rdata(vram_rdata),
        .eram_rdata(eram_rdata), .wram_rdata(wram_rdata), .hram_rdata(hram_rdata),
        .joy_rdata(joy_rdata), .vreg_rdata(vreg_rdata), .region_sel(region_sel),
        .region_we(region_we), .mem_index(mem_index), .tile_stb(tile_stb),
        .tile_addr(tile_addr), .tile_data(tile_data), .overlay_on(overlay_on)
    );

    function automatic logic [7:0] f_rom(input logic [15:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
    endfunction
    function automatic logic [7:0] f_ram(input logic [15:0] a, input logic [7:0] k);
        return a[7:0] ^ {3'b0, a[12:8]} ^ k;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares registered read data after each read edge
    always @(posedge clk) begin
        if (rst_n && cpu_rd) begin
            #1;
            if (exp_q.size() > 0) begin
                string t;
                logic [7:0] e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {24'd0, cpu_rdata}, {24'd0, e});
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, input logic [7:0] exp,
                           input logic [7:0] sel, input logic [14:0] idx, input string req);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        exp_q.push_back(exp); tag_q.push_back(req);
        #1;
        check({req, " sel"}, {24'd0, region_sel}, {24'd0, sel});
        if (sel != 8'h00) check({req, " index"}, {17'd0, mem_index}, {17'd0, idx});
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d,
                            input logic [7:0] we, input logic [14:0] idx, input string req);
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b1; cpu_rd = 1'b0; cpu_wdata = d;
        #1;
        check({req, " we"}, {24'd0, region_we}, {24'd0, we});
        if (we != 8'h00) check({req, " index"}, {17'd0, mem_index}, {17'd0, idx});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        check("R1 overlay", {31'd0, overlay_on}, 32'd1);
        check("R1 rdata", {24'd0, cpu_rdata}, 32'd0);

        do_read(16'h0010, 8'h10 ^ 8'hB0, 8'h01, 15'h0010, "R2 boot read");
        do_read(16'h00FF, f_rom(16'h00FF), 8'h02, 15'h00FF, "R2 0x00FF from rom");
        do_write(16'h0100, 8'h55, 8'h00, 15'h0, "R5 rom write ignored");
        do_write(16'h7ABC, 8'h55, 8'h00, 15'h0, "R5 rom write ignored hi");
        do_read(16'h00FE, 8'hFE ^ 8'hB0, 8'h01, 15'h00FE, "R3 last boot byte");
        idle();
        check("R3 overlay cleared", {31'd0, overlay_on}, 32'd0);
        do_read(16'h0010, f_rom(16'h0010), 8'h02, 15'h0010, "R3 rom after retire");
        do_read(16'h00FE, f_rom(16'h00FE), 8'h02, 15'h00FE, "R3 0x00FE after retire");
        do_read(16'h4567, f_rom(16'h4567), 8'h02, 15'h4567, "R5 rom read");
        do_read(16'h8123, f_ram(16'h8123, 8'h11), 8'h04, 15'h0123, "R6 vram read");
        do_read(16'hA456, f_ram(16'hA456, 8'h22), 8'h08, 15'h0456, "R6 eram read");
        do_read(16'hC789, f_ram(16'hC789, 8'h44), 8'h10, 15'h0789, "R6 wram read");
        do_read(16'hE789, f_ram(16'hC789, 8'h44), 8'h10, 15'h0789, "R7 mirror read");
        do_read(16'hFD00, f_ram(16'hDD00, 8'h44), 8'h10, 15'h1D00, "R7 mirror top");
        do_read(16'hFF85, 8'h85, 8'h20, 15'h0005, "R8 hram read");
        do_read(16'hFF00, 8'hCF, 8'h40, 15'h0, "R9 joypad read");
        do_read(16'hFF45, 8'h85, 8'h80, 15'h0005, "R9 video reg read");
        do_read(16'hFE10, 8'h00, 8'h00, 15'h0, "R11 oam hole read");
        do_read(16'hFF10, 8'h00, 8'h00, 15'h0, "R11 io hole read");
        do_write(16'hFE20, 8'h77, 8'h00, 15'h0, "R11 hole write");

        do_write(16'h9000, 8'hA7, 8'h04, 15'h1000, "R6 vram write");
        check("R10 tile strobe", {31'd0, tile_stb}, 32'd1);
        check("R10 tile addr", {19'd0, tile_addr}, 32'h1000);
        check("R10 tile data", {24'd0, tile_data}, 32'hA7);
        do_write(16'h9800, 8'hA8, 8'h04, 15'h1800, "R6 vram write map");
        check("R10 no strobe at 0x9800", {31'd0, tile_stb}, 32'd0);
        do_write(16'hB001, 8'h01, 8'h08, 15'h1001, "R6 eram write");
        do_write(16'hE123, 8'h02, 8'h10, 15'h0123, "R7 mirror write");
        do_write(16'hFFFF, 8'h03, 8'h20, 15'h007F, "R8 hram write");
        do_write(16'hFF7F, 8'h04, 8'h80, 15'h003F, "R9 video reg write");

        idle();
        #1;
        check("R13 idle sel", {24'd0, region_sel}, 32'd0);
        check("R13 idle we", {24'd0, region_we}, 32'd0);
        @(negedge clk);
        check("R12 rdata holds", {24'd0, cpu_rdata}, 32'd0);

        do_reset();
        #1;
        check("R1 overlay after re-reset", {31'd0, overlay_on}, 32'd1);
        do_write(16'hFF50, 8'h01, 8'h80, 15'h0010, "R4 exit write");
        idle();
        check("R4 overlay cleared", {31'd0, overlay_on}, 32'd0);
        do_read(16'h0020, f_rom(16'h0020), 8'h02, 15'h0020, "R4 rom after exit");
        idle();
        idle();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule